// File: doc/BRIEF.md
# Self-Starting Serial Pattern Generator

This block emits a fixed periodic bit pattern one bit per clock. Inside is a feedback shift register. The top stage loads a feedback bit computed from the current register contents, and every other stage moves one place toward bit 0. The serial output is bit 0.

The pattern and its length are elaboration-time parameters. The register width and the feedback function are derived from them while the design elaborates. Bit 0 of the pattern parameter is the first bit emitted after reset. A pattern built from identical repeated sub-blocks is first reduced to its shortest period.

Every register state that the pattern cycle does not visit gets a feedback value chosen so that the generator reaches the cycle within a number of clocks equal to the register width. No separate lock-up detector is needed. The full register state is exposed on a port for observation.

Top module: `selfstart_pattern_gen`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, loads the seed state. In the seed state, register bit k holds pattern bit (k mod P), where P is the reduced period. The default pattern 9'b010000110 gives seed 6.
- R2: On each clock with reset low, register bits [n-2:0] take the previous bits [n-1:1], where n is the register width.
- R3: The register width n is the smallest width for which all P cyclic n-bit windows of the reduced pattern are distinct. For the default pattern, n is 4 and the state cycle from reset is 6, 3, 1, 0, 8, 4, 2, 9, 12, after which it repeats.
- R4: The serial output equals register bit 0. Once the register is in the cycle, the output repeats the reduced pattern, in pattern bit order, with period exactly P.
- R5: When all-zeros is not a cycle state, the clock after an all-zeros state sets the top register bit to 1.
- R6: When all-ones is not a cycle state, the clock after an all-ones state sets the top register bit to 0.
- R7: From any of the 2^n register states, the state is in the cycle after at most n clocks, and it stays in the cycle from then on.
- R8: A pattern made of identical repeated sub-blocks runs at the sub-block period. The pattern 9'b101101101 gives a 2-bit register with the state cycle 1, 2, 3 and a serial output period of 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; loads the seed state |
| serOut | output | 1 | Serial pattern bit (register bit 0) |
| stateOut | output | REG_W | Full register state for observation |

## Verification
From the ports, the register only ever moves through cycle states. The unused states, which are the reason for the escape rules and the bound on locking, cannot be reached by driving inputs.

The bench therefore releases reset and, in the same half clock, overwrites the register with each of the 2^n values in turn. It then follows the shift relation, the top-bit escape values and the number of clocks until the state lands in the cycle. After that it checks the output phase against the pattern.

A second instance, built with a repeated pattern, provides the case where all-zeros is unused.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int MAX_PAT = 32;
  typedef logic [MAX_PAT-1:0] patVec_t;

  typedef struct packed {
    logic loadSeed;
    logic fbBit;
  } ctlStrobe_t;

  // Cyclic window of width w starting at phase a of a pattern of period per.
  function automatic patVec_t window(patVec_t pat, int per, int a, int w);
    patVec_t v;
    v = '0;
    for (int k = 0; k < w; k++) v[k] = pat[(a + k) % per];
    return v;
  endfunction

  // Shortest period that divides len and reproduces the whole pattern.
  function automatic int basePeriod(patVec_t pat, int len);
    for (int per = 1; per <= len; per++) begin
      if (len % per == 0) begin
        bit same;
        same = 1'b1;
        for (int i = 0; i < len; i++)
          if (pat[i] != pat[(i + per) % len]) same = 1'b0;
        if (same) return per;
      end
    end
    return len;
  endfunction

  // Smallest register width at which all cyclic windows differ.
  function automatic int winWidth(patVec_t pat, int per);
    for (int w = 1; w <= per; w++) begin
      bit distinct;
      distinct = 1'b1;
      for (int a = 0; a < per; a++)
        for (int b = a + 1; b < per; b++)
          if (window(pat, per, a, w) == window(pat, per, b, w)) distinct = 1'b0;
      if (distinct) return w;
    end
    return per;
  endfunction
endpackage

// File: rtl/psg_feedback_ctl.sv
module psg_feedback_ctl #(
  parameter int REG_W = 4,
  parameter int PERIOD = 9,
  parameter pgen_pkg::patVec_t PAT = pgen_pkg::patVec_t'(9'b010000110)
) (
  input  logic                   rst,
  input  logic [REG_W-1:0]       stateQ,
  output pgen_pkg::ctlStrobe_t   strobe
);
  localparam int STATES = 1 << REG_W;

  // For each state, find the cycle state sharing the longest run of top
  // bits with it and feed that state's next pattern bit. The matched run
  // then grows by one every clock, so the cycle is reached within REG_W
  // clocks. All-zeros and all-ones outside the cycle get fixed escape bits.
  function automatic logic [STATES-1:0] buildTable();
    logic [STATES-1:0] tbl;
    tbl = '0;
    for (int s = 0; s < STATES; s++) begin
      int best;
      logic fb;
      best = -1;
      fb = 1'b0;
      for (int t = 0; t < PERIOD; t++) begin
        pgen_pkg::patVec_t cs;
        int m;
        bit run;
        cs = pgen_pkg::window(PAT, PERIOD, t, REG_W);
        m = 0;
        run = 1'b1;
        for (int k = REG_W - 1; k >= 0; k--) begin
          if (run && (s[k] == cs[k])) m++;
          else run = 1'b0;
        end
        if (m > best) begin
          best = m;
          fb = PAT[(t + REG_W) % PERIOD];
        end
      end
      if (best < REG_W && s == 0) fb = 1'b1;
      else if (best < REG_W && s == STATES - 1) fb = 1'b0;
      tbl[s] = fb;
    end
    return tbl;
  endfunction

  localparam logic [STATES-1:0] FB_TABLE = buildTable();

  always_comb begin
    strobe.loadSeed = rst;
    strobe.fbBit    = FB_TABLE[stateQ];
  end
endmodule

// File: rtl/psg_shift_path.sv
module psg_shift_path #(
  parameter int REG_W = 4,
  parameter logic [REG_W-1:0] SEED = '0
) (
  input  logic                 clk,
  input  pgen_pkg::ctlStrobe_t strobe,
  output logic [REG_W-1:0]     stateQ
);
  logic [REG_W-1:0] nextState;

  generate
    if (REG_W == 1) begin : g_single
      always_comb nextState = strobe.fbBit;
    end else begin : g_multi
      always_comb nextState = {strobe.fbBit, stateQ[REG_W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.loadSeed) stateQ <= SEED;
    else                 stateQ <= nextState;
  end
endmodule

// File: rtl/selfstart_pattern_gen.sv
module selfstart_pattern_gen #(
  parameter int PAT_LEN = 9,
  parameter logic [PAT_LEN-1:0] PATTERN = 9'b010000110,
  localparam int PERIOD = pgen_pkg::basePeriod(pgen_pkg::patVec_t'(PATTERN), PAT_LEN),
  localparam int REG_W = pgen_pkg::winWidth(pgen_pkg::patVec_t'(PATTERN), PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             serOut,
  output logic [REG_W-1:0] stateOut
);
  localparam pgen_pkg::patVec_t PAT_EXT = pgen_pkg::patVec_t'(PATTERN);
  localparam logic [REG_W-1:0] SEED = REG_W'(pgen_pkg::window(PAT_EXT, PERIOD, 0, REG_W));

  pgen_pkg::ctlStrobe_t strobe;
  logic [REG_W-1:0]     stateQ;

  psg_feedback_ctl #(.REG_W(REG_W), .PERIOD(PERIOD), .PAT(PAT_EXT)) uCtl (
    .rst(rst), .stateQ(stateQ), .strobe(strobe)
  );

  psg_shift_path #(.REG_W(REG_W), .SEED(SEED)) uPath (
    .clk(clk), .strobe(strobe), .stateQ(stateQ)
  );

  assign serOut   = stateQ[0];
  assign stateOut = stateQ;
endmodule

// File: rtl/psg_checker.sv
module psg_checker #(
  parameter int REG_W = 4,
  parameter int PERIOD = 9,
  parameter pgen_pkg::patVec_t PAT = '0
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] stateOut
);
  localparam int CNT_W = $clog2(REG_W + 2);

  function automatic bit valueInCycle(logic [REG_W-1:0] v);
    bit hit;
    hit = 1'b0;
    for (int t = 0; t < PERIOD; t++)
      if (v == REG_W'(pgen_pkg::window(PAT, PERIOD, t, REG_W))) hit = 1'b1;
    return hit;
  endfunction

  localparam bit ZERO_USED = valueInCycle('0);
  localparam bit ONES_USED = valueInCycle('1);

  logic             inCycle;
  logic [CNT_W-1:0] outCnt;

  always_comb inCycle = valueInCycle(stateOut);

  always_ff @(posedge clk) begin
    if (rst)                   outCnt <= '0;
    else if (inCycle)          outCnt <= '0;
    else if (outCnt != '1)     outCnt <= outCnt + 1'b1;
  end

  generate
    if (REG_W > 1) begin : g_shift
      a_r2_shift: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stateOut[REG_W-2:0] == $past(stateOut[REG_W-1:1]));
    end
    if (!ZERO_USED) begin : g_zero
      a_r5_zero_escape: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stateOut) == '0) |-> stateOut[REG_W-1]);
    end
    if (!ONES_USED) begin : g_ones
      a_r6_ones_escape: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stateOut) == '1) |-> !stateOut[REG_W-1]);
    end
  endgenerate

  a_r7_lock_bound: assert property (@(posedge clk) disable iff (rst)
    outCnt <= CNT_W'(REG_W));

  a_r7_stay_locked: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inCycle)) |-> inCycle);
endmodule

bind selfstart_pattern_gen psg_checker #(
  .REG_W(REG_W), .PERIOD(PERIOD), .PAT(pgen_pkg::patVec_t'(PATTERN))
) u_chk (.clk(clk), .rst(rst), .stateOut(stateOut));

// File: tb/selfstart_pattern_gen_bench.sv
module selfstart_pattern_gen_bench;
  localparam logic [8:0] PAT     = 9'b010000110;
  localparam logic [8:0] PAT_REP = 9'b101101101;
  localparam int N = 4;
  localparam int P = 9;

  int cyc[9]    = '{6, 3, 1, 0, 8, 4, 2, 9, 12};
  int repCyc[3] = '{1, 2, 3};
  bit repBits[3] = '{1'b1, 1'b0, 1'b1};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serOut, serOut2;
  logic [3:0] stateOut;
  logic [1:0] state2;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  selfstart_pattern_gen u_selfstart_pattern_gen (
    .clk(clk), .rst(rst), .serOut(serOut), .stateOut(stateOut)
  );

  selfstart_pattern_gen #(.PAT_LEN(9), .PATTERN(PAT_REP)) u_selfstart_pattern_gen_rep (
    .clk(clk), .rst(rst), .serOut(serOut2), .stateOut(state2)
  );

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int phaseOf(logic [3:0] v);
    for (int j = 0; j < P; j++) if (cyc[j] == int'(v)) return j;
    return -1;
  endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: seed after reset
    check(stateOut == 4'd6, "R1 seed", stateOut, 6);
    check(serOut == 1'b0, "R1 first bit", serOut, 0);
    check(state2 == 2'd1, "R8 seed", state2, 1);
    rst = 1'b0;

    // R3 / R4 / R8: free run from reset for three periods
    for (int k = 1; k <= 3 * P; k++) begin
      @(negedge clk);
      check(int'(stateOut) == cyc[k % P], "R3 cycle", stateOut, cyc[k % P]);
      check(serOut == PAT[k % P], "R4 output", serOut, PAT[k % P]);
      check(int'(state2) == repCyc[k % 3], "R8 state", state2, repCyc[k % 3]);
      check(serOut2 == repBits[k % 3], "R8 output", serOut2, repBits[k % 3]);
    end

    // R2 / R6 / R7 / R4: start from every register value
    for (int v = 0; v < 16; v++) begin
      logic [3:0] prev;
      int lockAt;
      int ph;
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      force u_selfstart_pattern_gen.uPath.stateQ = 4'(v);
      #1 release u_selfstart_pattern_gen.uPath.stateQ;
      prev = 4'(v);
      ph = phaseOf(prev);
      lockAt = (ph >= 0) ? 0 : -1;
      for (int c = 1; c <= N + 2 * P; c++) begin
        @(negedge clk);
        check(stateOut[2:0] == prev[3:1], "R2 shift", stateOut[2:0], prev[3:1]);
        if (c == 1 && v == 15)
          check(stateOut[3] == 1'b0, "R6 ones escape", stateOut[3], 0);
        if (lockAt >= 0) begin
          ph = (ph + 1) % P;
          check(int'(stateOut) == cyc[ph], "R7 stays in cycle", stateOut, cyc[ph]);
          check(serOut == PAT[ph], "R4 locked output", serOut, PAT[ph]);
        end else begin
          ph = phaseOf(stateOut);
          if (ph >= 0) lockAt = c;
        end
        prev = stateOut;
      end
      check(lockAt >= 0 && lockAt <= N, "R7 lock bound", lockAt, N);
    end

    // R5: all-zeros is outside the cycle of the repeated pattern
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    force u_selfstart_pattern_gen_rep.uPath.stateQ = 2'b00;
    #1 release u_selfstart_pattern_gen_rep.uPath.stateQ;
    @(negedge clk);
    check(state2[1] == 1'b1, "R5 zero escape", state2[1], 1);
    check(state2 == 2'd2, "R5 escape state", state2, 2);
    @(negedge clk);
    check(state2 == 2'd3, "R8 relock", state2, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule